// File: doc/BRIEF.md
# Serial Converter Output Interface Emulator

This block reproduces the device-side digital behaviour of a 14-bit serial converter in its three-wire chip-select readout mode, so that a host's serial reader can be brought up against synthesizable logic instead of the real part. A rising edge on the convert line, with the serial data input held high, starts a conversion timer. When the timer expires, the block captures a 14-bit sample from a parallel input port and enters the acquisition phase.

A later falling edge on the convert line drives the most significant bit onto the serial data output and asserts the output enable. Each falling edge of the serial clock then moves the output one bit toward the least significant bit. The output enable drops after the fourteenth serial clock falling edge, or earlier if the convert line rises. All three serial inputs are asynchronous to the system clock. They pass through a two-stage synchroniser before their edges are detected. A phase output reports conversion, acquisition or readout.

Top module: `serial_adc_emu`

## Requirements
- R1: After reset, `phase_o` is 0 (acquisition), `sdo_oe_o` is low and `sdo_o` is low. `sdo_o` is low whenever `sdo_oe_o` is low.
- R2: A convert rising edge while no conversion runs starts a conversion when SDI has been high for the two latest synchronised samples. `phase_o` becomes 1 and `sdo_oe_o` is low. A convert rising edge with SDI low starts nothing.
- R3: A conversion lasts exactly `CONV_CYCLES` system clock cycles from the cycle it starts. Convert edges during a conversion neither restart it nor enable the output.
- R4: `sample_i` is captured in the last cycle of the conversion. Changes to `sample_i` before or after that cycle have no effect on the value read out.
- R5: A convert falling edge in acquisition, with a sample captured since the last readout began, sets `phase_o` to 2 and `sdo_oe_o` high, with `sdo_o` showing sample bit 13.
- R6: During readout, serial clock falling edge k (1 to 13) puts sample bit 13-k on `sdo_o`. Serial clock edges outside readout do not move the captured sample.
- R7: The 14th serial clock falling edge of a readout drops `sdo_oe_o` and returns `phase_o` to 0.
- R8: A convert rising edge during readout drops `sdo_oe_o` at once. With SDI high it also starts a new conversion; with SDI low the phase returns to 0.
- R9: Each captured sample is read out at most once. A convert falling edge with no new capture since the last readout began leaves `sdo_oe_o` low.
- R10: An input change takes effect at the third system clock rising edge after it. Conversion and readout are never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| conv_i | input | 1 | Convert / chip-select line, asynchronous |
| sck_i | input | 1 | Serial clock from the host, asynchronous |
| sdi_i | input | 1 | Serial data input, high selects chip-select mode |
| sample_i | input | 14 | Parallel sample value to be captured |
| sdo_o | output | 1 | Serial data output value |
| sdo_oe_o | output | 1 | Output enable; low means high impedance |
| phase_o | output | 2 | 0 acquisition, 1 conversion, 2 readout |

## Verification
The assertions take for granted that the convert line and the serial clock never change twice inside three system clock cycles. Under that condition the synchroniser delivers every edge, and a convert rise and fall can never coincide with a serial clock edge in a way that hides one of them. They also take for granted that SDI is settled before the convert rising edge it qualifies. The stimulus drives every input on the falling system clock edge and holds each level for at least three cycles. It raises SDI several cycles before any convert edge, which keeps every sequence inside these conditions.

// File: rtl/adc_emu_pkg.sv
package adc_emu_pkg;
  typedef enum logic [1:0] {
    PH_ACQ  = 2'd0,
    PH_CONV = 2'd1,
    PH_READ = 2'd2
  } phase_e;
endpackage

// File: rtl/adc_sync_edge.sv
module adc_sync_edge #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] lvl_o,
  output logic [WIDTH-1:0] prev_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q, stg_d;
  logic [WIDTH-1:0]             prev_q, prev_d;

  always_comb begin
    stg_d[0] = d_i;
    for (int s = 1; s < STAGES; s++) stg_d[s] = stg_q[s-1];
    prev_d = stg_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q  <= '0;
      prev_q <= '0;
    end else begin
      stg_q  <= stg_d;
      prev_q <= prev_d;
    end
  end

  assign lvl_o  = stg_q[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
  parameter int CONV_CYCLES = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(CONV_CYCLES + 1);
  localparam logic [CW-1:0] LOADV = CW'(CONV_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;
  logic          take;

  assign take = start_i && !busy_q;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (take) begin
      cnt_d  = LOADV;
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);

  // R2
  start_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> busy_q && (cnt_q == LOADV));
  // R3
  conv_runs_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0) |=> busy_q && (cnt_q == $past(cnt_q) - CW'(1)));
  // R3
  conv_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q == '0) |=> !busy_q);
endmodule

// File: rtl/adc_readout.sv
module adc_readout #(
  parameter int NBITS = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_i,
  input  logic [NBITS-1:0] cap_data_i,
  input  logic             begin_i,
  input  logic             adv_i,
  input  logic             abort_i,
  output logic             oe_o,
  output logic             sdo_o
);
  localparam int IW = $clog2(NBITS);
  localparam logic [IW-1:0] LAST = IW'(NBITS - 1);

  logic [NBITS-1:0] sh_q, sh_d;
  logic [IW-1:0]    left_q, left_d;
  logic             oe_q, oe_d;
  logic             fresh_q, fresh_d;

  always_comb begin
    sh_d    = sh_q;
    left_d  = left_q;
    oe_d    = oe_q;
    fresh_d = fresh_q;
    if (cap_i) begin
      sh_d    = cap_data_i;
      fresh_d = 1'b1;
    end
    if (abort_i) begin
      oe_d = 1'b0;
    end else if (begin_i && fresh_q && !oe_q) begin
      oe_d    = 1'b1;
      left_d  = LAST;
      fresh_d = 1'b0;
    end else if (adv_i && oe_q) begin
      if (left_q == '0) begin
        oe_d = 1'b0;
      end else begin
        sh_d   = sh_q << 1;
        left_d = left_q - IW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      left_q  <= '0;
      oe_q    <= 1'b0;
      fresh_q <= 1'b0;
    end else begin
      sh_q    <= sh_d;
      left_q  <= left_d;
      oe_q    <= oe_d;
      fresh_q <= fresh_d;
    end
  end

  assign oe_o  = oe_q;
  assign sdo_o = oe_q & sh_q[NBITS-1];

  // R4
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_i |=> sh_q == $past(cap_data_i));
  // R5
  open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (begin_i && fresh_q && !oe_q && !abort_i) |=> oe_q && (left_q == LAST));
  // R6
  shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q && adv_i && !abort_i && left_q != '0) |=> oe_q && (sh_q == ($past(sh_q) << 1)));
  // R7
  last_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q && adv_i && !abort_i && left_q == '0) |=> !oe_q);
  // R8
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> !oe_q);
  // R9
  once_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fresh_q && !oe_q && !cap_i) |=> !oe_q);
  // R1
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_q |-> !sdo_o);
endmodule

// File: rtl/serial_adc_emu.sv
module serial_adc_emu
  import adc_emu_pkg::*;
#(
  parameter int NBITS       = 14,
  parameter int CONV_CYCLES = 40,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_i,
  input  logic             sck_i,
  input  logic             sdi_i,
  input  logic [NBITS-1:0] sample_i,
  output logic             sdo_o,
  output logic             sdo_oe_o,
  output logic [1:0]       phase_o
);
  localparam int NIN = 3;
  localparam int IX_CONV = 0;
  localparam int IX_SCK  = 1;
  localparam int IX_SDI  = 2;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sn = rs_q[1];

  logic [NIN-1:0] lvl, prev;
  adc_sync_edge #(.WIDTH(NIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_sn),
    .d_i    ({sdi_i, sck_i, conv_i}),
    .lvl_o  (lvl),
    .prev_o (prev)
  );

  logic conv_rise, conv_fall, sck_fall, sdi_high;
  assign conv_rise = lvl[IX_CONV] & ~prev[IX_CONV];
  assign conv_fall = ~lvl[IX_CONV] & prev[IX_CONV];
  assign sck_fall  = ~lvl[IX_SCK] & prev[IX_SCK];
  assign sdi_high  = lvl[IX_SDI] & prev[IX_SDI];

  logic busy, done, oe, sdo;

  adc_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_sn),
    .start_i (conv_rise & sdi_high),
    .busy_o  (busy),
    .done_o  (done)
  );

  adc_readout #(.NBITS(NBITS)) u_read (
    .clk        (clk),
    .rst_n      (rst_sn),
    .cap_i      (done),
    .cap_data_i (sample_i),
    .begin_i    (conv_fall & ~busy),
    .adv_i      (sck_fall),
    .abort_i    (conv_rise),
    .oe_o       (oe),
    .sdo_o      (sdo)
  );

  phase_e phase;
  always_comb begin
    if (busy)    phase = PH_CONV;
    else if (oe) phase = PH_READ;
    else         phase = PH_ACQ;
  end

  assign phase_o  = phase;
  assign sdo_oe_o = oe;
  assign sdo_o    = sdo;

  // R10
  exclusive_phase_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !(busy && oe));
  // R2
  start_quiets_output_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(busy) |-> !oe);
  // R3
  no_open_in_conv_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (busy && !oe) |=> !oe);
endmodule

// File: tb/sim_serial_adc_emu.sv
`timescale 1ns/1ps
module sim_serial_adc_emu;
  localparam int NB   = 14;
  localparam int CONV = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic conv = 1'b0, sck = 1'b0, sdi = 1'b0;
  logic [NB-1:0] sample = '0;
  logic sdo, oe;
  logic [1:0] phase;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  serial_adc_emu #(.NBITS(NB), .CONV_CYCLES(CONV)) u0 (
    .clk(clk), .rst_n(rst_n), .conv_i(conv), .sck_i(sck), .sdi_i(sdi),
    .sample_i(sample), .sdo_o(sdo), .sdo_oe_o(oe), .phase_o(phase)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // wait n rising edges, then settle on the next falling edge
  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic start_conv(input logic [NB-1:0] s);
    sample = s;
    sdi = 1'b1;
    cyc(4);
    conv = 1'b1;
    cyc(CONV + 6);
    chk("R3 conversion done", phase, 0);
  endtask

  task automatic sck_pulse();
    sck = 1'b1;
    cyc(3);
    sck = 1'b0;
    cyc(4);
  endtask

  task automatic read_all(input logic [NB-1:0] s, input string tag);
    conv = 1'b0;
    cyc(4);
    chk({"R5 open ", tag}, oe, 1);
    chk({"R5 phase ", tag}, phase, 2);
    chk({"R5 msb ", tag}, sdo, s[NB-1]);
    for (int k = 1; k < NB; k++) begin
      sck_pulse();
      chk({"R6 bit ", tag}, sdo, s[NB-1-k]);
      chk({"R6 oe ", tag}, oe, 1);
    end
    sck_pulse();
    chk({"R7 close oe ", tag}, oe, 0);
    chk({"R7 close phase ", tag}, phase, 0);
  endtask

  task automatic t_reset();
    chk("R1 phase", phase, 0);
    chk("R1 oe", oe, 0);
    chk("R1 sdo", sdo, 0);
  endtask

  task automatic t_sdi_low();
    sdi = 1'b0;
    cyc(4);
    conv = 1'b1;
    cyc(4);
    chk("R2 sdi low no start", phase, 0);
    conv = 1'b0;
    cyc(4);
    chk("R9 nothing captured", oe, 0);
  endtask

  // exact duration, edges ignored inside, sample captured at the end
  task automatic t_conv_timing();
    sample = 14'h2A5C;
    sdi = 1'b1;
    cyc(4);
    conv = 1'b1;               // start registers on the third rising edge
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk("R2 started", phase, 1);
    chk("R2 oe low", oe, 0);
    conv = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R3 fall ignored phase", phase, 1);
    chk("R3 fall ignored oe", oe, 0);
    conv = 1'b1;
    sample = 14'h1D63;
    repeat (CONV + 2 - 10) @(posedge clk);
    @(negedge clk);
    chk("R3 still converting", phase, 1);
    @(posedge clk);
    @(negedge clk);
    chk("R3 ended on time", phase, 0);
    chk("R3 no output yet", oe, 0);
    sample = 14'h0F0F;
    cyc(3);
    read_all(14'h1D63, "R4 latched");
  endtask

  task automatic t_stale();
    sdi = 1'b0;
    cyc(4);
    conv = 1'b1;
    cyc(4);
    conv = 1'b0;
    cyc(4);
    chk("R9 stale oe", oe, 0);
    chk("R9 stale phase", phase, 0);
  endtask

  task automatic t_idle_sck_and_abort();
    start_conv(14'h3C96);
    for (int k = 0; k < 3; k++) sck_pulse();
    chk("R6 idle sck no open", oe, 0);
    conv = 1'b0;
    cyc(4);
    chk("R6 idle sck msb kept", sdo, 1);
    for (int k = 1; k <= 5; k++) sck_pulse();
    chk("R6 bit8", sdo, 0);          // 14'h3C96 bit 8
    sample = 14'h2BCD;
    conv = 1'b1;
    cyc(4);
    chk("R8 abort oe", oe, 0);
    chk("R8 abort restarts", phase, 1);
    cyc(CONV + 2);
    chk("R8 new conversion done", phase, 0);
    read_all(14'h2BCD, "after abort");
    start_conv(14'h1555);
    conv = 1'b0;
    cyc(4);
    chk("R5 open again", oe, 1);
    sck_pulse();
    sdi = 1'b0;
    cyc(4);
    conv = 1'b1;
    cyc(4);
    chk("R8 abort sdi low oe", oe, 0);
    chk("R8 abort sdi low phase", phase, 0);
    chk("R8 abort sdo low", sdo, 0);
    conv = 1'b0;
    cyc(4);
    chk("R9 aborted sample not reread", oe, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(6);
    t_reset();
    t_sdi_low();
    t_conv_timing();
    t_stale();
    t_idle_sck_and_abort();
    summary();
  end
endmodule